// File: doc/BRIEF.md
# Character LCD 4-bit Message Writer

This block drives a two-line, sixteen-column character display over a four-bit data bus. After reset it runs the display's power-up initialization on its own and holds `busy_o` high. It then waits for a request. A message store holds 32 full-screen messages of 256 bits each. A start pulse selects one entry, and the block streams its 32 characters to the display, one four-bit half at a time.

Each byte goes out as two nibble transfers on the upper data lines. Each transfer has its own enable pulse, and data and register-select are held steady while enable is high. All timing is given as clock-cycle parameters, so one netlist can serve any clock rate. The display is never read, so the read/write line stays at write.

Top module: `lcd4_msg_writer`

## Requirements
- R1: From reset until initialization ends, `busy_o` is 1 and `lcd_e_o` is 0. No enable pulse starts before `PWR_CYC` cycles have passed since reset release.
- R2: The first four enable pulses carry nibbles 0x3, 0x3, 0x3, 0x2, all with RS=0. They are separated by at least `LONG_CYC`, `SHORT_CYC` and `GAP_CYC` low cycles, in that order, and `GAP_CYC` follows the 0x2.
- R3: Initialization then sends the instruction bytes 0x28, 0x06, 0x0C and 0x01 with RS=0. After 0x01 the bus stays idle for at least `CLR_CYC` cycles.
- R4: A byte is sent as its bits [7:4] and then its bits [3:0], each with its own enable pulse of at least `PW_CYC` cycles. DB and RS do not change while enable is high.
- R5: Between the last pulse of one byte and the first pulse of the next, enable is low for at least `GAP_CYC` cycles. This holds unless a longer wait applies.
- R6: A screen is sent as instruction 0x80, then characters 0..15 with RS=1, then instruction 0xC0, then characters 16..31 with RS=1. Character k sits at bits [255-8k -: 8] of the message, so character 0 is the most significant byte.
- R7: `lcd_rw_o` is 0 at all times.
- R8: A write with `msg_we_i`=1 stores `msg_wdata_i` at entry `msg_waddr_i` (0..31). A start streams the entry named by `msg_sel_i` as it stood on the clock edge where the start was accepted.
- R9: A `start_i` that arrives while `busy_o` is 1 is ignored. It adds no transfer, and the screen in progress is unchanged.
- R10: When the block is idle, `start_i`=1 makes `busy_o` go to 1 from the next clock edge. `busy_o` returns to 0 after the wait that follows the last character. Once it is 0, no further pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_we_i | input | 1 | Message store write enable |
| msg_waddr_i | input | 5 | Message store write entry |
| msg_wdata_i | input | 256 | Screen contents to store, character 0 in the top byte |
| start_i | input | 1 | Request to show a stored message |
| msg_sel_i | input | 5 | Entry to show, sampled with start_i |
| busy_o | output | 1 | Initialization or screen transfer in progress |
| lcd_rs_o | output | 1 | 0 for instruction, 1 for character data |
| lcd_rw_o | output | 1 | Read/write select, held at write (0) |
| lcd_e_o | output | 1 | Transfer enable |
| lcd_db_o | output | 4 | Data nibble for display lines DB7..DB4 |

## Verification
The assertions assume that `start_i`, `msg_sel_i`, `msg_we_i` and `msg_waddr_i` are never unknown after reset. They also assume that every cycle parameter is at least one. The bench drives all inputs at the falling edge with defined values and fills every message entry with seeded random contents. It also pulses start during initialization and in the middle of a screen, to cover the ignored-request case. Small cycle parameters let the bench run the whole initialization and many screens.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  typedef enum logic [1:0] {
    WT_GAP,
    WT_LONG,
    WT_SHORT,
    WT_CLEAR
  } wait_e;

  typedef struct packed {
    logic       is_byte;
    logic       rs;
    logic [7:0] val;
    wait_e      wsel;
  } lcd_op_t;

  localparam int         INIT_STEPS   = 8;
  localparam logic [7:0] CMD_SET_ADDR = 8'h80;

  // power-up program: three wake nibbles, bus-width nibble, then configuration
  function automatic lcd_op_t init_op(input logic [2:0] step);
    lcd_op_t op;
    case (step)
      3'd0:    op = '{is_byte: 1'b0, rs: 1'b0, val: 8'h03, wsel: WT_LONG};
      3'd1:    op = '{is_byte: 1'b0, rs: 1'b0, val: 8'h03, wsel: WT_SHORT};
      3'd2:    op = '{is_byte: 1'b0, rs: 1'b0, val: 8'h03, wsel: WT_GAP};
      3'd3:    op = '{is_byte: 1'b0, rs: 1'b0, val: 8'h02, wsel: WT_GAP};
      3'd4:    op = '{is_byte: 1'b1, rs: 1'b0, val: 8'h28, wsel: WT_GAP};
      3'd5:    op = '{is_byte: 1'b1, rs: 1'b0, val: 8'h06, wsel: WT_GAP};
      3'd6:    op = '{is_byte: 1'b1, rs: 1'b0, val: 8'h0C, wsel: WT_GAP};
      default: op = '{is_byte: 1'b1, rs: 1'b0, val: 8'h01, wsel: WT_CLEAR};
    endcase
    return op;
  endfunction

endpackage

// File: rtl/lcd4_msg_mem.sv
module lcd4_msg_mem #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (rd_en_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  AST_SEL_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !$isunknown(raddr_i)); // R8
  AST_WADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown(waddr_i)); // R8

endmodule

// File: rtl/lcd4_timer.sv
module lcd4_timer #(
  parameter int W       = 22,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  AST_LOAD_WHEN_EXPIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> done_o); // R5

endmodule

// File: rtl/lcd4_strobe.sv
module lcd4_strobe #(
  parameter int SU_CYC  = 15,
  parameter int PW_CYC  = 120,
  parameter int HLD_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [3:0] nib_i,
  input  logic       rs_i,
  output logic       done_o,
  output logic       busy_o,
  output logic [3:0] lcd_db_o,
  output logic       lcd_rs_o,
  output logic       lcd_e_o
);
  localparam int MAX_C = (SU_CYC > PW_CYC) ? ((SU_CYC > HLD_CYC) ? SU_CYC : HLD_CYC)
                                           : ((PW_CYC > HLD_CYC) ? PW_CYC : HLD_CYC);
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [1:0] {P_IDLE, P_SU, P_PW, P_HLD} phase_e;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       db_q;
  logic             rs_q;
  logic             e_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
      db_q    <= '0;
      rs_q    <= 1'b0;
      e_q     <= 1'b0;
    end else begin
      case (phase_q)
        P_IDLE: if (req_i) begin
          db_q    <= nib_i;
          rs_q    <= rs_i;
          cnt_q   <= CNT_W'(SU_CYC - 1);
          phase_q <= P_SU;
        end
        P_SU: if (cnt_q == '0) begin
          e_q     <= 1'b1;
          cnt_q   <= CNT_W'(PW_CYC - 1);
          phase_q <= P_PW;
        end else cnt_q <= cnt_q - CNT_W'(1);
        P_PW: if (cnt_q == '0) begin
          e_q     <= 1'b0;
          cnt_q   <= CNT_W'(HLD_CYC - 1);
          phase_q <= P_HLD;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: if (cnt_q == '0) phase_q <= P_IDLE;
                 else cnt_q <= cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign done_o   = (phase_q == P_HLD) && (cnt_q == '0);
  assign busy_o   = (phase_q != P_IDLE);
  assign lcd_db_o = db_q;
  assign lcd_rs_o = rs_q;
  assign lcd_e_o  = e_q;

  // independent run-length counter for the enable pulse
  logic [CNT_W-1:0] e_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   e_run_q <= '0;
    else if (!e_q)                                 e_run_q <= '0;
    else if (e_run_q != CNT_W'(PW_CYC))            e_run_q <= e_run_q + CNT_W'(1);
  end

  AST_E_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(e_q) |-> (e_run_q == CNT_W'(PW_CYC))); // R4
  AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_q && $past(e_q)) |-> ($stable(db_q) && $stable(rs_q))); // R4
  AST_REQ_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !e_q); // R4

endmodule

// File: rtl/lcd4_seq.sv
module lcd4_seq
  import lcd4_pkg::*;
#(
  parameter int CHARS       = 32,
  parameter int CHAR_W      = 8,
  parameter int LINE_CHARS  = 16,
  parameter int LINE_STRIDE = 64,
  parameter int PWR_CYC     = 3750000,
  parameter int LONG_CYC    = 1025000,
  parameter int SHORT_CYC   = 25000,
  parameter int GAP_CYC     = 10000,
  parameter int CLR_CYC     = 410000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic                    busy_o,
  output logic                    rd_en_o,
  input  logic [CHARS*CHAR_W-1:0] rd_data_i,
  output logic                    strb_req_o,
  output logic [3:0]              strb_nib_o,
  output logic                    strb_rs_o,
  input  logic                    strb_done_i,
  input  logic                    strb_busy_i
);
  localparam int SCREEN_W = CHARS * CHAR_W;
  localparam int LINES    = CHARS / LINE_CHARS;
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int POS_W    = $clog2(LINE_CHARS + 1);
  localparam int IDX_W    = $clog2(CHARS);
  localparam int MAX_A    = (PWR_CYC > LONG_CYC) ? PWR_CYC : LONG_CYC;
  localparam int MAX_B    = (SHORT_CYC > GAP_CYC) ? SHORT_CYC : GAP_CYC;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W    = (MAX_C > CLR_CYC) ? MAX_C : CLR_CYC;
  localparam int TMR_W    = $clog2(MAX_W + 1);

  typedef enum logic [2:0] {
    S_POWER, S_ISSUE_HI, S_WAIT_HI, S_ISSUE_LO, S_WAIT_LO, S_GAP, S_IDLE, S_FETCH
  } state_e;

  state_e              state_q;
  logic                init_q;
  logic [2:0]          step_q;
  logic [LINE_W-1:0]   line_q;
  logic [POS_W-1:0]    pos_q;
  logic [SCREEN_W-1:0] screen_q;

  logic [CHAR_W-1:0] chars [CHARS];
  for (genvar k = 0; k < CHARS; k++) begin : g_chars
    assign chars[k] = screen_q[SCREEN_W-1-k*CHAR_W -: CHAR_W];
  end

  lcd_op_t          op_c;
  logic [IDX_W-1:0] char_idx;
  logic             last_c;
  logic [TMR_W-1:0] wait_c;
  logic             tmr_load, tmr_done;

  assign char_idx = IDX_W'(int'(line_q) * LINE_CHARS + int'(pos_q) - 1);

  always_comb begin
    if (init_q) begin
      op_c = init_op(step_q);
    end else begin
      op_c.is_byte = 1'b1;
      op_c.wsel    = WT_GAP;
      if (pos_q == '0) begin
        op_c.rs  = 1'b0;
        op_c.val = CMD_SET_ADDR | 8'(int'(line_q) * LINE_STRIDE);
      end else begin
        op_c.rs  = 1'b1;
        op_c.val = 8'(chars[char_idx]);
      end
    end
  end

  always_comb begin
    case (op_c.wsel)
      WT_LONG:  wait_c = TMR_W'(LONG_CYC);
      WT_SHORT: wait_c = TMR_W'(SHORT_CYC);
      WT_CLEAR: wait_c = TMR_W'(CLR_CYC);
      default:  wait_c = TMR_W'(GAP_CYC);
    endcase
  end

  assign last_c = init_q ? (step_q == 3'(INIT_STEPS - 1))
                         : ((line_q == LINE_W'(LINES - 1)) && (pos_q == POS_W'(LINE_CHARS)));

  assign tmr_load = strb_done_i &&
                    ((state_q == S_WAIT_LO) || (state_q == S_WAIT_HI && !op_c.is_byte));

  lcd4_timer #(.W(TMR_W), .RST_VAL(PWR_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (wait_c),
    .done_o (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_POWER;
      init_q   <= 1'b1;
      step_q   <= '0;
      line_q   <= '0;
      pos_q    <= '0;
      screen_q <= '0;
    end else begin
      case (state_q)
        S_POWER:    if (tmr_done) state_q <= S_ISSUE_HI;
        S_ISSUE_HI: state_q <= S_WAIT_HI;
        S_WAIT_HI:  if (strb_done_i) state_q <= op_c.is_byte ? S_ISSUE_LO : S_GAP;
        S_ISSUE_LO: state_q <= S_WAIT_LO;
        S_WAIT_LO:  if (strb_done_i) state_q <= S_GAP;
        S_GAP: if (tmr_done) begin
          if (last_c) begin
            state_q <= S_IDLE;
            init_q  <= 1'b0;
          end else begin
            state_q <= S_ISSUE_HI;
            if (init_q) step_q <= step_q + 3'd1;
            else if (pos_q == POS_W'(LINE_CHARS)) begin
              pos_q  <= '0;
              line_q <= line_q + LINE_W'(1);
            end else pos_q <= pos_q + POS_W'(1);
          end
        end
        S_IDLE: if (start_i) state_q <= S_FETCH;
        default: begin
          screen_q <= rd_data_i;
          pos_q    <= '0;
          line_q   <= '0;
          state_q  <= S_ISSUE_HI;
        end
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign rd_en_o    = (state_q == S_IDLE) && start_i;
  assign strb_req_o = (state_q == S_ISSUE_HI) || (state_q == S_ISSUE_LO);
  assign strb_rs_o  = op_c.rs;
  assign strb_nib_o = (state_q == S_ISSUE_HI && op_c.is_byte) ? op_c.val[7:4] : op_c.val[3:0];

  AST_REQ_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_req_o |-> !strb_busy_i); // R4
  AST_DONE_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_done_i |-> (state_q == S_WAIT_HI || state_q == S_WAIT_LO)); // R4
  AST_INIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> busy_o); // R1
  AST_SCREEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && busy_o && state_q != S_FETCH) |=> $stable(screen_q)); // R9

endmodule

// File: rtl/lcd4_msg_writer.sv
module lcd4_msg_writer #(
  parameter int ADDR_W      = 5,
  parameter int CHARS       = 32,
  parameter int CHAR_W      = 8,
  parameter int LINE_CHARS  = 16,
  parameter int LINE_STRIDE = 64,
  parameter int PWR_CYC     = 3750000,
  parameter int LONG_CYC    = 1025000,
  parameter int SHORT_CYC   = 25000,
  parameter int GAP_CYC     = 10000,
  parameter int CLR_CYC     = 410000,
  parameter int SU_CYC      = 15,
  parameter int PW_CYC      = 120,
  parameter int HLD_CYC     = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    msg_we_i,
  input  logic [ADDR_W-1:0]       msg_waddr_i,
  input  logic [CHARS*CHAR_W-1:0] msg_wdata_i,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       msg_sel_i,
  output logic                    busy_o,
  output logic                    lcd_rs_o,
  output logic                    lcd_rw_o,
  output logic                    lcd_e_o,
  output logic [3:0]              lcd_db_o
);
  localparam int SCREEN_W = CHARS * CHAR_W;

  logic                rd_en;
  logic [SCREEN_W-1:0] rd_data;
  logic                strb_req, strb_rs, strb_done, strb_busy;
  logic [3:0]          strb_nib;

  lcd4_msg_mem #(.ADDR_W(ADDR_W), .DATA_W(SCREEN_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (msg_we_i),
    .waddr_i (msg_waddr_i),
    .wdata_i (msg_wdata_i),
    .rd_en_i (rd_en),
    .raddr_i (msg_sel_i),
    .rdata_o (rd_data)
  );

  lcd4_seq #(
    .CHARS(CHARS), .CHAR_W(CHAR_W), .LINE_CHARS(LINE_CHARS), .LINE_STRIDE(LINE_STRIDE),
    .PWR_CYC(PWR_CYC), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC),
    .GAP_CYC(GAP_CYC), .CLR_CYC(CLR_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .rd_en_o     (rd_en),
    .rd_data_i   (rd_data),
    .strb_req_o  (strb_req),
    .strb_nib_o  (strb_nib),
    .strb_rs_o   (strb_rs),
    .strb_done_i (strb_done),
    .strb_busy_i (strb_busy)
  );

  lcd4_strobe #(.SU_CYC(SU_CYC), .PW_CYC(PW_CYC), .HLD_CYC(HLD_CYC)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (strb_req),
    .nib_i    (strb_nib),
    .rs_i     (strb_rs),
    .done_o   (strb_done),
    .busy_o   (strb_busy),
    .lcd_db_o (lcd_db_o),
    .lcd_rs_o (lcd_rs_o),
    .lcd_e_o  (lcd_e_o)
  );

  assign lcd_rw_o = 1'b0;

endmodule

// File: tb/lcd4_msg_writer_tb_top.sv
module lcd4_msg_writer_tb_top;
  localparam int PWR = 200, LONG = 100, SHORT = 40, GAP = 20, CLR = 60;
  localparam int SU = 2, PW = 4, HLD = 2;
  localparam int MAXN = 4096;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         we, start;
  logic [4:0]   waddr, sel;
  logic [255:0] wdata;
  logic         busy, rs, rw, e;
  logic [3:0]   db;

  always #2 clk = ~clk;

  lcd4_msg_writer #(
    .PWR_CYC(PWR), .LONG_CYC(LONG), .SHORT_CYC(SHORT), .GAP_CYC(GAP), .CLR_CYC(CLR),
    .SU_CYC(SU), .PW_CYC(PW), .HLD_CYC(HLD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .msg_we_i(we), .msg_waddr_i(waddr), .msg_wdata_i(wdata),
    .start_i(start), .msg_sel_i(sel), .busy_o(busy), .lcd_rs_o(rs), .lcd_rw_o(rw),
    .lcd_e_o(e), .lcd_db_o(db)
  );

  int n_chk = 0, n_fail = 0;
  logic [255:0] mem_m [32];
  logic [3:0]   exp_nib [MAXN];
  logic         exp_rs  [MAXN];
  int           exp_gap [MAXN];
  int           exp_len = 0, prev_wait = 0, n_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_nib(input logic [3:0] v, input logic r, input int g);
    exp_nib[exp_len] = v; exp_rs[exp_len] = r; exp_gap[exp_len] = g; exp_len++;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic r, input int after);
    push_nib(b[7:4], r, prev_wait);
    push_nib(b[3:0], r, 1);
    prev_wait = after;
  endtask

  function automatic logic [7:0] char_of(input logic [255:0] s, input int k);
    return s[255-8*k -: 8];
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // bus monitor
  logic       e_prev = 1'b0, cap_rs = 1'b0, stab_ok = 1'b1;
  logic [3:0] cap_nib = '0;
  int         lo_cnt = 0, hi_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      lo_cnt = 0;
      e_prev = 1'b0;
    end else begin
      if (e && !e_prev) begin
        chk(lo_cnt >= exp_gap[n_seen], (n_seen == 0) ? "R1" : (n_seen < 4) ? "R2" : "R5",
            "low cycles before pulse", 64'(lo_cnt), 64'(exp_gap[n_seen]));
        cap_nib = db; cap_rs = rs; stab_ok = 1'b1; hi_cnt = 1;
      end else if (e) begin
        hi_cnt++;
        if (db != cap_nib || rs != cap_rs) stab_ok = 1'b0;
      end else if (e_prev) begin
        chk(n_seen < exp_len, "R10", "unexpected pulse index", 64'(n_seen), 64'(exp_len));
        if (n_seen < exp_len) begin
          chk(cap_nib == exp_nib[n_seen] && cap_rs == exp_rs[n_seen],
              (n_seen < 4) ? "R2" : (n_seen < 12) ? "R3" : "R6 R8",
              "nibble/rs", 64'({cap_rs, cap_nib}), 64'({exp_rs[n_seen], exp_nib[n_seen]}));
        end
        chk(hi_cnt >= PW, "R4", "enable width", 64'(hi_cnt), 64'(PW));
        chk(stab_ok, "R4", "bus stable while enable high", 64'(stab_ok), 64'(1));
        chk(rw == 1'b0, "R7", "rw at pulse", 64'(rw), 64'(0));
        n_seen++;
        lo_cnt = 1;
      end else lo_cnt++;
      e_prev = e;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic write_msg(input logic [4:0] a, input logic [255:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d; mem_m[a] = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic run_screen(input logic [4:0] a, input bit poke);
    push_byte(8'h80, 1'b0, GAP);
    for (int k = 0; k < 16; k++) push_byte(char_of(mem_m[a], k), 1'b1, GAP);
    push_byte(8'hC0, 1'b0, GAP);
    for (int k = 16; k < 32; k++) push_byte(char_of(mem_m[a], k), 1'b1, GAP);
    @(negedge clk); start = 1'b1; sel = a;
    @(negedge clk); start = 1'b0; sel = ~a;
    chk(busy == 1'b1, "R10", "busy after accepted start", 64'(busy), 64'(1));
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1; sel = a ^ 5'd5;  // R9: must be ignored
      @(negedge clk); start = 1'b0;
    end
    wait_idle();
    repeat (GAP + 10) @(negedge clk);
    chk(n_seen == exp_len, "R9", "pulse count after screen", 64'(n_seen), 64'(exp_len));
    chk(busy == 1'b0, "R10", "busy after screen", 64'(busy), 64'(0));
  endtask

  initial begin
    void'($urandom(32'h1CD4));
    rst_n = 1'b0; we = 1'b0; start = 1'b0; waddr = '0; sel = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1", "busy in reset", 64'(busy), 64'(1));
    chk(e == 1'b0, "R1", "enable in reset", 64'(e), 64'(0));
    chk(rw == 1'b0, "R7", "rw in reset", 64'(rw), 64'(0));

    push_nib(4'h3, 1'b0, PWR);
    push_nib(4'h3, 1'b0, LONG);
    push_nib(4'h3, 1'b0, SHORT);
    push_nib(4'h2, 1'b0, GAP);
    prev_wait = GAP;
    push_byte(8'h28, 1'b0, GAP);
    push_byte(8'h06, 1'b0, GAP);
    push_byte(8'h0C, 1'b0, GAP);
    push_byte(8'h01, 1'b0, CLR);

    rst_n = 1'b1;
    @(negedge clk); start = 1'b1; sel = 5'd3;  // R9: start during init
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && e == 1'b0, "R1", "busy, no pulse early in init", 64'({busy, e}), 64'(2));

    for (int a = 0; a < 32; a++) write_msg(5'(a), rand256());

    wait_idle();
    chk(n_seen == 12, "R3", "pulses at end of init", 64'(n_seen), 64'(12));
    repeat (CLR + 10) @(negedge clk);
    chk(busy == 1'b0 && n_seen == 12, "R9", "start during init ignored",
        64'({busy, 8'(n_seen)}), 64'(12));

    run_screen(5'd0, 1'b0);
    run_screen(5'd31, 1'b1);
    write_msg(5'd7, {256{1'b1}});
    write_msg(5'd8, '0);
    run_screen(5'd7, 1'b0);
    run_screen(5'd8, 1'b1);
    write_msg(5'd9, {8'h41, {30{8'h20}}, 8'h5A});
    run_screen(5'd9, 1'b0);
    for (int i = 0; i < 4; i++) run_screen(5'($urandom_range(0, 31)), bit'(i[0]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected idle");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule